// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a synchronous host and an external byte-wide asynchronous static RAM with a 17-bit address. The host presents one request at a time: a strobe, a read/write select, an address and, for writes, a data byte. The controller plays out the memory's pin sequence and reports completion with a one-clock done pulse. On reads, the captured byte appears on the read-data output at the same time as that pulse.

The memory side has registered address and data, plus the active-low chip enable, output enable and write enable strobes. The bidirectional data bus is handled as separate output, input and driver-enable signals, so the board or pad ring owns the tri-state buffer. All phase lengths are clock counts. They are derived at elaboration time from nanosecond timing parameters and the clock period, using ceiling division with a floor of one cycle.

A parameter keeps output enable low through writes. In that mode the write pulse is stretched and the data driver stays off until the memory's own output has turned off. After reset, the controller holds off every request until the power-up settling time has elapsed.

Top module: `sram_ctl`

## Requirements
- R1: After reset, `ready` is low, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are high and `mem_dq_oe` is low, for 25000 cycles (100 µs at a 4 ns clock). `ready` is first seen high in the 25000th cycle after reset is released.
- R2: A read (`wr_sel`=0) spends one setup cycle with the new address on `mem_addr` and all strobes high. It then holds `mem_ce_n` and `mem_oe_n` low with `mem_we_n` high for 3 cycles. `done` is high in the 5th cycle after the accepting edge.
- R3: `rdata` takes the byte on `mem_dq_in` at the end of the last of the 3 read cycles. It holds that value until the next read completes, including across writes.
- R4: A write keeps `mem_ce_n` low from its setup cycle through a `mem_we_n` low pulse of 4 cycles. `mem_addr` does not change while `mem_ce_n` is low. `mem_we_n` is never low while `mem_ce_n` is high.
- R5: With output enable held low during writes (default), `mem_dq_oe` is off for the first 2 cycles of the write-enable pulse. It is on for the last 2 cycles of the pulse and for one cycle after it. In that following cycle `mem_ce_n` and `mem_we_n` are both high. The controller never drives `mem_dq_out` while the memory is still driving the bus.
- R6: `done` lasts exactly one cycle. For a write, `done` is high in the 7th cycle after the accepting edge, and the byte is stored at `mem_addr` when `mem_we_n` rises.
- R7: A request raised while `ready` is low is ignored. It starts no access and changes no stored byte.
- R8: `ready` is high in the cycle where `done` is high, and a request presented in that cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Request strobe, sampled when `ready` is high |
| wr_sel | input | 1 | 1 = write, 0 = read |
| addr | input | 17 | Host byte address |
| wdata | input | 8 | Host write byte |
| rdata | output | 8 | Last byte read |
| done | output | 1 | One-cycle completion pulse |
| ready | output | 1 | Controller idle and able to accept a request |
| mem_addr | output | 17 | Memory address pins |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Driver enable for `mem_dq_out` |
| mem_dq_in | input | 8 | Data returned from the memory bus |

## Verification
Completion of one access and acceptance of the next can fall in the same cycle: `done` and `ready` are both high, and a new `req` is taken on the following edge. The bench provokes this by issuing every entry of its vector table as soon as the previous one reports `done`. Each access's latency is measured from the cycle its request is driven, so a dropped or delayed acceptance shows up as a latency mismatch or a wrong byte on readback. A behavioural memory beside the controller also flags any cycle where both sides drive the bus. This matters most at the write-to-read and read-to-write seams that the back-to-back walk creates.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PWRUP,
      ST_RD_SETUP,
      ST_RD_WAIT,
      ST_RD_CAP,
      ST_WR_SETUP,
      ST_WR_PULSE,
      ST_WR_RECOV
   } ctl_state_e;

   // nanoseconds to whole clock periods, never below one
   function automatic int cyc_of(input int ns, input int clk_ns);
      int c;
      c = (ns + clk_ns - 1) / clk_ns;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
`timescale 1ns/1ps
module sram_ctl_timer #(
   parameter int CNT_W   = 16,
   parameter int RST_VAL = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt,
   output logic             zero
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= CNT_W'(RST_VAL);
      else if (load)
         cnt <= load_val;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);

endmodule

// File: rtl/sram_ctl_fsm.sv
`timescale 1ns/1ps
module sram_ctl_fsm
   import sram_ctl_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int RD_CYC = 3,
   parameter int WR_PW  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic             wr_sel,
   input  logic             zero,
   output ctl_state_e       state,
   output logic             load,
   output logic [CNT_W-1:0] load_val,
   output logic             ready,
   output logic             done
);

   localparam logic [CNT_W-1:0] RD_WAIT_LD = CNT_W'((RD_CYC > 1) ? RD_CYC - 2 : 0);
   localparam logic [CNT_W-1:0] WR_PW_LD   = CNT_W'(WR_PW - 1);
   localparam bit               HAS_WAIT   = (RD_CYC > 1);

   ctl_state_e nxt;

   always_comb begin
      nxt      = state;
      load     = 1'b0;
      load_val = '0;
      unique case (state)
         ST_PWRUP:    if (zero) nxt = ST_IDLE;
         ST_IDLE:     if (req)  nxt = wr_sel ? ST_WR_SETUP : ST_RD_SETUP;
         ST_RD_SETUP: begin
            if (HAS_WAIT) begin
               nxt      = ST_RD_WAIT;
               load     = 1'b1;
               load_val = RD_WAIT_LD;
            end else begin
               nxt = ST_RD_CAP;
            end
         end
         ST_RD_WAIT:  if (zero) nxt = ST_RD_CAP;
         ST_RD_CAP:   nxt = ST_IDLE;
         ST_WR_SETUP: begin
            nxt      = ST_WR_PULSE;
            load     = 1'b1;
            load_val = WR_PW_LD;
         end
         ST_WR_PULSE: if (zero) nxt = ST_WR_RECOV;
         ST_WR_RECOV: nxt = ST_IDLE;
         default:     nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_PWRUP;
         done  <= 1'b0;
      end else begin
         state <= nxt;
         done  <= (state == ST_RD_CAP) || (state == ST_WR_RECOV);
      end
   end

   assign ready = (state == ST_IDLE);

endmodule

// File: rtl/sram_ctl_io.sv
`timescale 1ns/1ps
module sram_ctl_io
   import sram_ctl_pkg::*;
#(
   parameter int ADDR_W      = 17,
   parameter int DATA_W      = 8,
   parameter int CNT_W       = 16,
   parameter int HZ_CYC      = 2,
   parameter int WR_PW       = 4,
   parameter bit HOLD_OE_LOW = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  ctl_state_e        state,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              accept,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [DATA_W-1:0] wdata_in,
   output logic [DATA_W-1:0] rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in
);

   logic in_read, in_wr_sel, in_pulse, pulse_drv;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_addr   <= '0;
         mem_dq_out <= '0;
         rdata      <= '0;
      end else begin
         if (accept) begin
            mem_addr   <= addr_in;
            mem_dq_out <= wdata_in;
         end
         if (state == ST_RD_CAP)
            rdata <= mem_dq_in;
      end
   end

   assign in_read   = (state == ST_RD_WAIT) || (state == ST_RD_CAP);
   assign in_pulse  = (state == ST_WR_PULSE);
   assign in_wr_sel = (state == ST_WR_SETUP) || in_pulse;

   // driver gating: with OE held low the memory needs time to release the bus
   generate
      if (HZ_CYC > 0) begin : g_turnoff_wait
         localparam logic [CNT_W-1:0] DRV_AT = CNT_W'(WR_PW - 1 - HZ_CYC);
         assign pulse_drv = (cnt <= DRV_AT);
      end else begin : g_drive_whole_pulse
         assign pulse_drv = 1'b1;
      end
   endgenerate

   assign mem_ce_n  = !(in_read || in_wr_sel);
   assign mem_oe_n  = !(in_read || (HOLD_OE_LOW && in_wr_sel));
   assign mem_we_n  = !in_pulse;
   assign mem_dq_oe = (in_pulse && pulse_drv) || (state == ST_WR_RECOV);

endmodule

// File: rtl/sram_ctl.sv
`timescale 1ns/1ps
module sram_ctl
   import sram_ctl_pkg::*;
#(
   parameter int ADDR_W        = 17,
   parameter int DATA_W        = 8,
   parameter int CLK_PERIOD_NS = 4,
   parameter int T_RC_NS       = 10,
   parameter int T_AA_NS       = 10,
   parameter int T_DOE_NS      = 5,
   parameter int T_WC_NS       = 10,
   parameter int T_PWE_NS      = 7,
   parameter int T_AW_NS       = 7,
   parameter int T_SD_NS       = 6,
   parameter int T_HZWE_NS     = 5,
   parameter int T_PWRUP_NS    = 100000,
   parameter bit HOLD_OE_LOW   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              wr_sel,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              done,
   output logic              ready,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in
);

   localparam int RD_CYC = imax(cyc_of(T_RC_NS, CLK_PERIOD_NS),
                                imax(cyc_of(T_AA_NS, CLK_PERIOD_NS),
                                     cyc_of(T_DOE_NS, CLK_PERIOD_NS)));
   localparam int HZ_CYC = HOLD_OE_LOW ? cyc_of(T_HZWE_NS, CLK_PERIOD_NS) : 0;
   localparam int WR_PW  = imax(imax(cyc_of(T_PWE_NS, CLK_PERIOD_NS),
                                     cyc_of(T_AW_NS, CLK_PERIOD_NS)),
                                imax(HZ_CYC + cyc_of(T_SD_NS, CLK_PERIOD_NS),
                                     cyc_of(T_WC_NS, CLK_PERIOD_NS) - 2));
   localparam int PU_CYC = cyc_of(T_PWRUP_NS, CLK_PERIOD_NS);
   localparam int CNT_W  = $clog2(imax(PU_CYC, imax(RD_CYC, WR_PW)) + 1);

   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("sram_ctl: address and data widths must be positive");
      end
      if (CLK_PERIOD_NS < 1) begin : g_bad_clk
         $error("sram_ctl: clock period must be at least 1 ns");
      end
   endgenerate

   ctl_state_e       state;
   logic             load, zero, accept;
   logic [CNT_W-1:0] load_val, cnt;

   assign accept = req && ready;

   sram_ctl_timer #(.CNT_W(CNT_W), .RST_VAL(PU_CYC - 1)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
      .cnt(cnt), .zero(zero)
   );

   sram_ctl_fsm #(.CNT_W(CNT_W), .RD_CYC(RD_CYC), .WR_PW(WR_PW)) u_fsm (
      .clk(clk), .rst_n(rst_n), .req(req), .wr_sel(wr_sel), .zero(zero),
      .state(state), .load(load), .load_val(load_val),
      .ready(ready), .done(done)
   );

   sram_ctl_io #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
      .HZ_CYC(HZ_CYC), .WR_PW(WR_PW), .HOLD_OE_LOW(HOLD_OE_LOW)
   ) u_io (
      .clk(clk), .rst_n(rst_n), .state(state), .cnt(cnt), .accept(accept),
      .addr_in(addr), .wdata_in(wdata), .rdata(rdata),
      .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
      .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
      .mem_dq_in(mem_dq_in)
   );

endmodule

// File: rtl/sram_ctl_chk.sv
`timescale 1ns/1ps
module sram_ctl_chk #(
   parameter int ADDR_W = 17
) (
   input logic              clk,
   input logic              rst_n,
   input logic              done,
   input logic              ready,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_ce_n,
   input logic              mem_we_n,
   input logic              mem_dq_oe
);

   // R4: write strobe only inside a chip-enable window
   a_r4_we_with_ce: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> !mem_ce_n);

   // R4: address held steady across a selected window
   a_r4_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

   // R5: driver only during the write pulse or with the chip deselected
   a_r5_drive_safe: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> (!mem_we_n || mem_ce_n));

   // R6: completion pulse is a single cycle
   a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8: controller can take new work in the completion cycle
   a_r8_done_ready: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ready);

endmodule

bind sram_ctl sram_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .done(done), .ready(ready),
   .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
   .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_ctl_bench.sv
`timescale 1ns/1ps
module sram_ctl_bench;

   localparam int PU_EXP   = 25000;
   localparam int RD_LAT   = 5;
   localparam int WR_LAT   = 7;
   localparam int RD_LOW   = 3;
   localparam int WE_LOW   = 4;
   localparam int HZ_EXP   = 2;
   localparam int NVEC     = 10;

   // {is_write, address, write byte, expected read byte}
   localparam logic [33:0] VEC [NVEC] = '{
      {1'b1, 17'h00000, 8'hA5, 8'h00},
      {1'b1, 17'h1FFFF, 8'h5A, 8'h00},
      {1'b1, 17'h0ABCD, 8'h3C, 8'h00},
      {1'b0, 17'h00000, 8'h00, 8'hA5},
      {1'b0, 17'h1FFFF, 8'h00, 8'h5A},
      {1'b1, 17'h00000, 8'hFF, 8'h00},
      {1'b0, 17'h00000, 8'h00, 8'hFF},
      {1'b0, 17'h0ABCD, 8'h00, 8'h3C},
      {1'b1, 17'h10001, 8'h00, 8'h00},
      {1'b0, 17'h10001, 8'h00, 8'h00}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic        wr_sel = 1'b0;
   logic [16:0] addr = '0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic        done, ready;
   logic [16:0] mem_addr;
   logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
   logic [7:0]  mem_dq_out, mem_dq_in;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   sram_ctl u_sram_ctl (
      .clk(clk), .rst_n(rst_n), .req(req), .wr_sel(wr_sel), .addr(addr),
      .wdata(wdata), .rdata(rdata), .done(done), .ready(ready),
      .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
      .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
      .mem_dq_in(mem_dq_in)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // ---------------- cycle-level memory model ----------------
   bit [7:0]    mdl_mem [int];
   logic [7:0]  mdl_rd;
   int          rd_cnt = 0;
   int          wlow = 0;
   int          dcnt = 0;
   logic        prev_wr = 1'b0;
   logic [16:0] prev_addr = '0;
   logic [7:0]  prev_data = '0;
   logic        rd_active, mem_drv;

   assign rd_active = !mem_ce_n && !mem_oe_n && mem_we_n;
   assign mem_drv   = !mem_ce_n && !mem_oe_n && (mem_we_n || wlow < HZ_EXP);

   always_comb begin
      mdl_rd = 8'h00;
      if (mdl_mem.exists(int'(mem_addr)))
         mdl_rd = mdl_mem[int'(mem_addr)];
   end

   assign mem_dq_in = (rd_active && rd_cnt >= RD_LOW) ? mdl_rd : 8'hEE;

   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_dq_oe)
            chk(!mem_drv, "R5 bus contention", 1, 0);
         if (prev_wr && (mem_we_n || mem_ce_n)) begin
            chk(wlow == WE_LOW, "R4 write pulse length", wlow, WE_LOW);
            chk(dcnt == WE_LOW - HZ_EXP, "R5 driven pulse cycles", dcnt, WE_LOW - HZ_EXP);
            chk(mem_dq_oe && mem_ce_n && mem_we_n, "R5 hold cycle pins",
                {mem_dq_oe, mem_ce_n, mem_we_n}, 3'b111);
            mdl_mem[int'(prev_addr)] = prev_data;
         end
         if (!mem_ce_n && !mem_we_n) begin
            wlow = wlow + 1;
            if (mem_dq_oe) dcnt = dcnt + 1;
         end else begin
            wlow = 0;
            dcnt = 0;
         end
         rd_cnt   = rd_active ? rd_cnt + 1 : 0;
         prev_wr  = !mem_ce_n && !mem_we_n;
         prev_addr = mem_addr;
         prev_data = mem_dq_out;
      end
   end

   // ---------------- host side ----------------
   task automatic do_op(input logic w, input logic [16:0] a, input logic [7:0] d,
                        output logic [7:0] rd, output int lat);
      while (!ready) @(negedge clk);
      req = 1'b1; wr_sel = w; addr = a; wdata = d;
      @(negedge clk);
      req = 1'b0;
      lat = 1;
      while (!done && lat < 50) begin
         @(negedge clk);
         lat++;
      end
      rd = rdata;
   endtask

   initial begin : main
      logic [7:0] rd;
      logic [7:0] last_rd;
      int lat;
      int n;
      bit idle_ok;

      repeat (3) @(negedge clk);
      chk(!ready && !done && mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe,
          "R1 reset state", {ready, done, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 6'b001110);
      rst_n = 1'b1;
      n = 0;
      idle_ok = 1'b1;
      while (!ready && n < PU_EXP + 10) begin
         @(negedge clk);
         n++;
         if (!ready && !(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe)) idle_ok = 1'b0;
      end
      chk(n == PU_EXP, "R1 power-up length", n, PU_EXP);
      chk(idle_ok, "R1 pins idle during power-up", idle_ok, 1);

      // table walk, each access issued in the previous one's done cycle (R8)
      last_rd = 8'h00;
      for (int i = 0; i < NVEC; i++) begin
         do_op(VEC[i][33], VEC[i][32:16], VEC[i][15:8], rd, lat);
         chk(done && ready, "R8 ready in done cycle", {done, ready}, 2'b11);
         if (VEC[i][33]) begin
            chk(lat == WR_LAT, "R6 write latency", lat, WR_LAT);
            chk(rd == last_rd, "R3 rdata held across write", rd, last_rd);
         end else begin
            chk(lat == RD_LAT, "R2 read latency", lat, RD_LAT);
            chk(rd == VEC[i][7:0], "R3 read data", rd, VEC[i][7:0]);
            last_rd = rd;
         end
      end

      // R6: done drops after one cycle
      @(negedge clk);
      chk(!done, "R6 done single cycle", done, 0);

      // R2: read pin pattern observed cycle by cycle
      req = 1'b1; wr_sel = 1'b0; addr = 17'h1FFFF;
      @(negedge clk);
      req = 1'b0;
      chk(mem_ce_n && mem_oe_n && mem_we_n && mem_addr == 17'h1FFFF,
          "R2 setup cycle", {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
      for (int k = 0; k < RD_LOW; k++) begin
         @(negedge clk);
         chk(!mem_ce_n && !mem_oe_n && mem_we_n, "R2 read strobes",
             {mem_ce_n, mem_oe_n, mem_we_n}, 3'b001);
      end
      @(negedge clk);
      chk(done && rdata == 8'h5A, "R2 read done and data", rdata, 8'h5A);

      // R7: requests during a busy read are ignored
      req = 1'b1; wr_sel = 1'b0; addr = 17'h0ABCD;
      @(negedge clk);
      wr_sel = 1'b1; wdata = 8'h77;
      chk(!ready, "R7 ready low while busy", ready, 0);
      @(negedge clk);
      @(negedge clk);
      req = 1'b0;
      n = 0;
      while (!done && n < 20) begin
         @(negedge clk);
         n++;
      end
      chk(rdata == 8'h3C, "R7 busy read data", rdata, 8'h3C);
      do_op(1'b0, 17'h0ABCD, 8'h00, rd, lat);
      chk(rd == 8'h3C, "R7 ignored write left byte unchanged", rd, 8'h3C);
      chk(lat == RD_LAT, "R7 no extra access queued", lat, RD_LAT);

      repeat (4) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule